// File: doc/BRIEF.md
# BCD Calendar Counter with Test Output

This block keeps wall-clock time and a calendar in packed BCD. It holds seconds, minutes, hours in 24-hour form, a day-of-week number, the date, the month and a two-digit year. The date counter knows the length of each month and adds 29 February in every year whose two-digit value is a multiple of four. A free-running enable at the oscillator rate (32768 pulses per second by default) goes through a prescaler that makes a one-second count enable. A carry from seconds moves through every field in the same clock cycle.

Software-facing logic loads all fields at once through a single strobe and reads them back on seven plain byte outputs. The load also restarts the prescaler, so the first second after a load is a full second. The seconds byte carries a stop flag that freezes the prescaler and every field. The day byte carries a test flag. While the test flag is set and the clock runs, the seconds LSB on the read port is replaced by a square wave from the same oscillator enable. No data stream passes through the block. The load strobe is taken in the cycle in which it is high, so it never waits and has no back-pressure.

Top module: `rtc_calendar`

## Requirements
- R1: Each read byte is packed BCD, with the tens digit in bits [7:4] and the units digit in bits [3:0]. Units roll from 9 to 0 with a carry into tens. Seconds and minutes count 00 to 59 and wrap to 00, and each wrap adds one to the next field.
- R2: Hours count 00 to 23. A units carry moves 09 to 10 and 19 to 20, and 23 wraps to 00 at the minute carry.
- R3: rd_sec bit 7 shows the stop flag, which is loaded from ld_sec bit 7. While it is 1, no field changes and the prescaler is frozen. A load with bit 7 at 0 resumes counting.
- R4: rd_day bit 6 shows the test flag, which is loaded from ld_day bit 6. When the test flag is 1 and the stop flag is 0, rd_sec bit 0 shows a square wave instead of the seconds units LSB. The wave is 0 right after a load and inverts once every TEST_DIV oscillator enables. When the clock is stopped, bit 0 shows the true LSB.
- R5: The day of week (rd_day bits [2:0]) counts 1 to 7. It advances on every midnight rollover and wraps from 7 to 1.
- R6: Months 01, 03, 05, 07, 08, 10 and 12 end on date 31. Months 04, 06, 09 and 11 end on 30. After the last date, the date returns to 01 and the month advances.
- R7: February ends on 29 when the year value is divisible by four (00 included) and on 28 otherwise.
- R8: The month wraps from 12 to 01 and the year wraps from 99 to 00. The whole cascade from seconds to year settles in one clock cycle.
- R9: When ld_strobe is high at a clock edge, all seven fields and both flags take the load values on that edge and the prescaler restarts. The next seconds increment then comes exactly SEC_DIV oscillator enables later.
- R10: The prescaler counts only cycles in which osc_en is high.
- R11: Reset gives 00:00:00, day 1, date 01, month 01, year 00, with both flags cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | One-cycle pulse at the oscillator rate |
| ld_strobe | input | 1 | Loads all fields and flags, restarts the prescaler |
| ld_sec | input | 8 | Load seconds BCD; bit 7 is the stop flag |
| ld_min | input | 8 | Load minutes BCD |
| ld_hour | input | 8 | Load hours BCD |
| ld_day | input | 8 | Load day of week in bits [2:0]; bit 6 is the test flag |
| ld_date | input | 8 | Load date BCD |
| ld_month | input | 8 | Load month BCD |
| ld_year | input | 8 | Load year BCD |
| rd_sec | output | 8 | Seconds with the stop flag in bit 7 and the test wave on bit 0 |
| rd_min | output | 8 | Minutes |
| rd_hour | output | 8 | Hours |
| rd_day | output | 8 | Day of week with the test flag in bit 6 |
| rd_date | output | 8 | Date |
| rd_month | output | 8 | Month |
| rd_year | output | 8 | Year |

## Verification
The bench builds the block with SEC_DIV = 8 and TEST_DIV = 2, so a second lasts eight oscillator enables and the test wave inverts every two. This brings every rollover into reach within a few cycles of a load: the minute, the midnight, the month end, the leap and non-leap February, and the year-99 cascade. The short test period lets single cycles tell the wave apart from the true seconds LSB. The bench also holds osc_en low for a known number of cycles to show that the prescaler stalls by exactly that amount.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned BYTE_W = 2 * NIB_W;
  localparam int unsigned NFIELD = 7;

  typedef logic [NIB_W-1:0]  nibble_t;
  typedef logic [BYTE_W-1:0] bcd_byte_t;

  // field slots, seconds first
  localparam int FIDX_SEC   = 0;
  localparam int FIDX_MIN   = 1;
  localparam int FIDX_HOUR  = 2;
  localparam int FIDX_DAY   = 3;
  localparam int FIDX_DATE  = 4;
  localparam int FIDX_MONTH = 5;
  localparam int FIDX_YEAR  = 6;

  function automatic logic nib_last(input nibble_t n);
    return (n >= nibble_t'(9));
  endfunction

  function automatic nibble_t nib_inc(input nibble_t n);
    return nib_last(n) ? nibble_t'(0) : n + nibble_t'(1);
  endfunction

  // year%4 from BCD: 10*T is 2*(T mod 2) mod 4
  function automatic logic year_is_leap(input bcd_byte_t yr);
    logic [3:0] s;
    s = {2'b00, yr[NIB_W], 1'b0} + yr[NIB_W-1:0];
    return (s[1:0] == 2'b00);
  endfunction

  function automatic bcd_byte_t last_date_of(input bcd_byte_t mon, input bcd_byte_t yr);
    case (mon)
      8'h02:                      return year_is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned SEC_DIV  = 32768,
  parameter int unsigned TEST_DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic sec_tick,
  output logic test_wave
);
  localparam int unsigned SEC_W  = (SEC_DIV  > 1) ? $clog2(SEC_DIV)  : 1;
  localparam int unsigned TEST_W = (TEST_DIV > 1) ? $clog2(TEST_DIV) : 1;
  localparam logic [SEC_W-1:0]  SEC_LAST  = SEC_W'(SEC_DIV - 1);
  localparam logic [TEST_W-1:0] TEST_LAST = TEST_W'(TEST_DIV - 1);

  logic [SEC_W-1:0]  sec_cnt;
  logic [TEST_W-1:0] tst_cnt;
  logic              wave_q;
  logic              flip;

  assign sec_tick  = run && (sec_cnt == SEC_LAST);
  assign flip      = run && (tst_cnt == TEST_LAST);
  assign test_wave = wave_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_cnt <= '0;
      tst_cnt <= '0;
      wave_q  <= 1'b0;
    end else if (restart) begin
      sec_cnt <= '0;
      tst_cnt <= '0;
      wave_q  <= 1'b0;
    end else if (run) begin
      sec_cnt <= sec_tick ? '0 : sec_cnt + 1'b1;
      tst_cnt <= flip ? '0 : tst_cnt + 1'b1;
      if (flip) wave_q <= ~wave_q;
    end
  end

  AST_IDLE_WAVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(test_wave)); // R10

  AST_RESTART_WAVE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !test_wave); // R9
endmodule

// File: rtl/rtc_bcd_pair.sv
module rtc_bcd_pair
  import rtc_cal_pkg::*;
#(
  parameter logic [7:0] MIN_VAL = 8'h00,
  parameter logic [7:0] RST_VAL = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic       inc,
  input  logic [7:0] max_val,
  output logic [7:0] val,
  output logic       at_max
);
  nibble_t tens_q;
  nibble_t units_q;

  assign val    = {tens_q, units_q};
  assign at_max = (val >= max_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tens_q  <= RST_VAL[7:4];
      units_q <= RST_VAL[3:0];
    end else if (load) begin
      tens_q  <= load_val[7:4];
      units_q <= load_val[3:0];
    end else if (inc) begin
      if (at_max) begin
        tens_q  <= MIN_VAL[7:4];
        units_q <= MIN_VAL[3:0];
      end else begin
        units_q <= nib_inc(units_q);
        if (nib_last(units_q)) tens_q <= nib_inc(tens_q);
      end
    end
  end

  AST_PAIR_WRAP_TO_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && at_max) |=> (val == MIN_VAL)); // R1

  AST_UNITS_STAY_DECIMAL: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && (val[3:0] <= 4'd9)) |=> (val[3:0] <= 4'd9)); // R1
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int unsigned SEC_DIV  = 32768,
  parameter int unsigned TEST_DIV = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_en,
  input  logic       ld_strobe,
  input  logic [7:0] ld_sec,
  input  logic [7:0] ld_min,
  input  logic [7:0] ld_hour,
  input  logic [7:0] ld_day,
  input  logic [7:0] ld_date,
  input  logic [7:0] ld_month,
  input  logic [7:0] ld_year,
  output logic [7:0] rd_sec,
  output logic [7:0] rd_min,
  output logic [7:0] rd_hour,
  output logic [7:0] rd_day,
  output logic [7:0] rd_date,
  output logic [7:0] rd_month,
  output logic [7:0] rd_year
);
  localparam logic [7:0] F_MIN  [NFIELD] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
  localparam logic [7:0] F_MAX  [NFIELD] = '{8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99};
  localparam logic [7:0] F_MASK [NFIELD] = '{8'h7F, 8'h7F, 8'h3F, 8'h07, 8'h3F, 8'h1F, 8'hFF};
  // fields whose wrap must coincide for this field to advance
  localparam logic [NFIELD-1:0] F_ANC [NFIELD] = '{
    7'b0000000, 7'b0000001, 7'b0000011, 7'b0000111,
    7'b0000111, 7'b0010111, 7'b0110111};
  localparam int unsigned STOP_BIT = 7;
  localparam int unsigned TEST_BIT = 6;

  logic              stop_q;
  logic              test_q;
  logic              run;
  logic              sec_tick;
  logic              test_wave;
  bcd_byte_t         ld_bus  [NFIELD];
  bcd_byte_t         field_v [NFIELD];
  logic [NFIELD-1:0] at_max;
  logic [NFIELD-1:0] inc_v;
  bcd_byte_t         date_last;
  bcd_byte_t         sec_flagged;

  assign ld_bus[FIDX_SEC]   = ld_sec;
  assign ld_bus[FIDX_MIN]   = ld_min;
  assign ld_bus[FIDX_HOUR]  = ld_hour;
  assign ld_bus[FIDX_DAY]   = ld_day;
  assign ld_bus[FIDX_DATE]  = ld_date;
  assign ld_bus[FIDX_MONTH] = ld_month;
  assign ld_bus[FIDX_YEAR]  = ld_year;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b0;
      test_q <= 1'b0;
    end else if (ld_strobe) begin
      stop_q <= ld_sec[STOP_BIT];
      test_q <= ld_day[TEST_BIT];
    end
  end

  assign run = osc_en && !stop_q;

  rtc_prescaler #(.SEC_DIV(SEC_DIV), .TEST_DIV(TEST_DIV)) u_presc (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (ld_strobe),
    .run       (run),
    .sec_tick  (sec_tick),
    .test_wave (test_wave)
  );

  assign date_last = last_date_of(field_v[FIDX_MONTH], field_v[FIDX_YEAR]);

  for (genvar i = 0; i < NFIELD; i++) begin : g_field
    bcd_byte_t max_i;
    if (i == FIDX_DATE) begin : g_dyn
      assign max_i = date_last;
    end else begin : g_fix
      assign max_i = F_MAX[i];
    end
    assign inc_v[i] = sec_tick && (&(at_max | ~F_ANC[i]));

    rtc_bcd_pair #(.MIN_VAL(F_MIN[i]), .RST_VAL(F_MIN[i])) u_pair (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld_strobe),
      .load_val (ld_bus[i] & F_MASK[i]),
      .inc      (inc_v[i]),
      .max_val  (max_i),
      .val      (field_v[i]),
      .at_max   (at_max[i])
    );
  end

  assign sec_flagged = field_v[FIDX_SEC] | {stop_q, 7'd0};
  assign rd_sec   = {sec_flagged[7:1], (test_q && !stop_q) ? test_wave : sec_flagged[0]};
  assign rd_min   = field_v[FIDX_MIN];
  assign rd_hour  = field_v[FIDX_HOUR];
  assign rd_day   = field_v[FIDX_DAY] | {1'b0, test_q, 6'd0};
  assign rd_date  = field_v[FIDX_DATE];
  assign rd_month = field_v[FIDX_MONTH];
  assign rd_year  = field_v[FIDX_YEAR];

  AST_STOP_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !ld_strobe) |=> ($stable(rd_sec) && $stable(rd_min) && $stable(rd_hour) &&
                                $stable(rd_date) && $stable(rd_month) && $stable(rd_year))); // R3

  AST_LOAD_MINUTES: assert property (@(posedge clk) disable iff (!rst_n)
    ld_strobe |=> (rd_min == ($past(ld_min) & 8'h7F))); // R9

  AST_WEEKDAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_v[FIDX_DAY] && !ld_strobe && (rd_day[2:0] == 3'd7)) |=> (rd_day[2:0] == 3'd1)); // R5

  AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_v[FIDX_YEAR] && !ld_strobe && (rd_year == 8'h99)) |=> (rd_year == 8'h00)); // R8

  AST_DATE_NOT_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_v[FIDX_DATE] && !ld_strobe && (rd_date == 8'h28) && (rd_month == 8'h02) &&
     !year_is_leap(rd_year)) |=> (rd_date == 8'h01)); // R7
endmodule

// File: tb/tb_rtc_calendar.sv
`timescale 1ns/1ps
module tb_rtc_calendar;
  localparam int SEC_DIV  = 8;
  localparam int TEST_DIV = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_en = 1'b1;
  logic ld_strobe = 1'b0;
  logic [7:0] ld_sec = '0, ld_min = '0, ld_hour = '0, ld_day = '0;
  logic [7:0] ld_date = '0, ld_month = '0, ld_year = '0;
  logic [7:0] rd_sec, rd_min, rd_hour, rd_day, rd_date, rd_month, rd_year;

  always #4 clk = ~clk;

  rtc_calendar #(.SEC_DIV(SEC_DIV), .TEST_DIV(TEST_DIV)) dut (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .ld_strobe(ld_strobe),
    .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour), .ld_day(ld_day),
    .ld_date(ld_date), .ld_month(ld_month), .ld_year(ld_year),
    .rd_sec(rd_sec), .rd_min(rd_min), .rd_hour(rd_hour), .rd_day(rd_day),
    .rd_date(rd_date), .rd_month(rd_month), .rd_year(rd_year));

  typedef struct {
    int          due;
    logic [55:0] exp;
    string       tag;
  } item_t;

  item_t sbq[$];
  item_t cur;
  int cyc = 0;
  int n_vec = 0;
  int n_bad = 0;
  logic [55:0] got;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare queued expectations when their cycle comes
  always @(negedge clk) begin
    got = {rd_sec, rd_min, rd_hour, rd_day, rd_date, rd_month, rd_year};
    if (sbq.size() > 0 && sbq[0].due < cyc) begin
      cur = sbq.pop_front();
      n_vec++;
      n_bad++;
      $display("FAIL %s: sample missed, actual %h expected %h", cur.tag, got, cur.exp);
    end
    while (sbq.size() > 0 && sbq[0].due == cyc) begin
      cur = sbq.pop_front();
      n_vec++;
      if (got !== cur.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", cur.tag, got, cur.exp);
      end
    end
  end

  task automatic push(input int due, input logic [55:0] e, input string tag);
    item_t it;
    it.due = due;
    it.exp = e;
    it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic start_load(input logic [55:0] v, input logic osc_off, output int c);
    @(posedge clk);
    #1;
    c = cyc;
    {ld_sec, ld_min, ld_hour, ld_day, ld_date, ld_month, ld_year} = v;
    ld_strobe = 1'b1;
    if (osc_off) osc_en = 1'b0;
  endtask

  task automatic finish_load(input int off);
    @(posedge clk);
    #1;
    ld_strobe = 1'b0;
    if (off > 0) begin
      repeat (off) @(posedge clk);
      #1;
      osc_en = 1'b1;
    end
  endtask

  task automatic drain();
    while (sbq.size() > 0) @(posedge clk);
    @(posedge clk);
  endtask

  // one load, then one second: loaded value, still loaded, incremented
  task automatic one_second(input logic [55:0] vin, input logic [55:0] vout, input string tag);
    int c;
    start_load(vin, 1'b0, c);
    push(c + 1, vin, {tag, " R9 load"});
    push(c + SEC_DIV, vin, {tag, " R9 full second"});
    push(c + 1 + SEC_DIV, vout, tag);
    finish_load(0);
    drain();
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    int c;
    repeat (2) @(posedge clk);
    #1;
    push(cyc, 56'h00_00_00_01_01_01_00, "R11 reset state");
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    drain();

    one_second(56'h59_34_12_03_15_06_23, 56'h00_35_12_03_15_06_23, "R1 minute carry");
    one_second(56'h39_10_05_02_14_02_11, 56'h40_10_05_02_14_02_11, "R1 units carry");
    one_second(56'h59_59_09_04_20_07_30, 56'h00_00_10_04_20_07_30, "R2 hour tens");
    one_second(56'h59_59_23_02_10_05_21, 56'h00_00_00_03_11_05_21, "R5 midnight weekday");
    one_second(56'h59_59_23_07_31_12_99, 56'h00_00_00_01_01_01_00, "R8 R5 year wrap");
    one_second(56'h59_59_23_01_30_04_22, 56'h00_00_00_02_01_05_22, "R6 april end");
    one_second(56'h59_59_23_05_30_03_22, 56'h00_00_00_06_31_03_22, "R6 march 30");
    one_second(56'h59_59_23_06_30_11_22, 56'h00_00_00_07_01_12_22, "R6 november end");
    one_second(56'h59_59_23_03_31_08_22, 56'h00_00_00_04_01_09_22, "R6 august end");
    one_second(56'h59_59_23_01_28_02_23, 56'h00_00_00_02_01_03_23, "R7 feb 23");
    one_second(56'h59_59_23_01_28_02_24, 56'h00_00_00_02_29_02_24, "R7 feb 24");
    one_second(56'h59_59_23_01_29_02_24, 56'h00_00_00_02_01_03_24, "R7 feb 29 end");
    one_second(56'h59_59_23_01_28_02_00, 56'h00_00_00_02_29_02_00, "R7 year 00 leap");
    one_second(56'h59_59_23_01_28_02_10, 56'h00_00_00_02_01_03_10, "R7 year 10");
    one_second(56'h59_59_23_01_28_02_12, 56'h00_00_00_02_29_02_12, "R7 year 12");

    // R3: stopped clock keeps every field
    start_load(56'hC5_00_08_03_03_03_03, 1'b0, c);
    push(c + 1, 56'hC5_00_08_03_03_03_03, "R3 stop loaded");
    push(c + 1 + 3 * SEC_DIV, 56'hC5_00_08_03_03_03_03, "R3 stop holds");
    finish_load(0);
    drain();
    one_second(56'h45_00_08_03_03_03_03, 56'h46_00_08_03_03_03_03, "R3 resume");

    // R10: five cycles without oscillator enable delay the second by five
    start_load(56'h10_20_01_01_05_05_05, 1'b1, c);
    push(c + SEC_DIV + 5, 56'h10_20_01_01_05_05_05, "R10 stalled");
    push(c + SEC_DIV + 6, 56'h11_20_01_01_05_05_05, "R10 delayed tick");
    finish_load(5);
    drain();

    // R4: test wave on seconds LSB
    start_load(56'h00_00_00_44_01_01_01, 1'b0, c);
    push(c + 1, 56'h00_00_00_44_01_01_01, "R4 wave low");
    push(c + 3, 56'h01_00_00_44_01_01_01, "R4 wave high");
    push(c + 5, 56'h00_00_00_44_01_01_01, "R4 wave low again");
    push(c + 7, 56'h01_00_00_44_01_01_01, "R4 wave high again");
    push(c + 10, 56'h00_00_00_44_01_01_01, "R4 wave hides LSB");
    finish_load(0);
    drain();

    // R4: stopped clock shows the true LSB
    start_load(56'h81_00_00_44_01_01_01, 1'b0, c);
    push(c + 1, 56'h81_00_00_44_01_01_01, "R4 stop true LSB");
    push(c + 3, 56'h81_00_00_44_01_01_01, "R4 stop no wave");
    finish_load(0);
    drain();

    report();
  end
endmodule